// File: doc/BRIEF.md
# Overhead Bit Insertion Interface

This block sits in the transmit path of a serial framer. A bit counter walks a fixed-length frame in which every `OH_STRIDE`-th position, starting at position 0, is an overhead slot. All other positions carry the payload input. One line-clock period before each overhead slot, the block raises a single-cycle enable so that external terminal equipment may supply its own value for that slot.

The equipment reacts on the falling edge. It drives the wanted bit on `oh_data` and raises `oh_insert`. On the next rising edge the block captures both, and it uses the captured bit in the slot of the frame being built at that moment. Each slot has a compile-time default bit taken from `DEFAULT_PAT`. Some slots are marked locked in `LOCK_MASK`. A request on a locked slot is dropped: the default goes out and `ins_reject` pulses. While `hdlc_mode` is high, the two external pins serve a different function, so no insertion takes place.

The serial output is registered. The bit for a position appears one cycle after the cycle in which the counter points at that position.

Top module: `ovh_insert`

## Requirements
- R1: `oh_enable` is high for exactly one clock cycle, in the cycle just before each overhead position. Overhead positions are the multiples of `OH_STRIDE` (0, 8, 16, 24 for the defaults) in a frame of `FRAME_LEN` positions numbered 0 upward.
- R2: An overhead slot with no accepted request carries bit `k` of `DEFAULT_PAT`, where `k` is position / `OH_STRIDE` (defaults 4'b1010: slots 0 and 2 send 0, slots 1 and 3 send 1).
- R3: If `oh_insert` is low at the rising edge that ends the enable cycle, the value on `oh_data` is ignored and the default is sent.
- R4: If `oh_insert` is high at that edge and the slot is not locked, the captured `oh_data` bit is sent in that same frame's slot. It appears on `ser_out` one cycle after the slot's counter cycle.
- R5: If the slot's bit in `LOCK_MASK` is 1 (default 4'b0100, which locks slot 2 at position 16), a request is discarded and the default is sent. `ins_reject` is high for one cycle, aligned with that slot's output bit.
- R6: While `hdlc_mode` is high at the capture edge, no insertion and no rejection occur, and the default is sent.
- R7: Non-overhead positions forward `payload_in` to `ser_out` with a latency of exactly one cycle.
- R8: Synchronous reset `rst` returns the counter to position 0 and drives `oh_enable`, `ser_out` and `ins_reject` low. The first slot after reset (position 0) sends its default.
- R9: Values on `oh_data` and `oh_insert` outside the capture edge that follows an enable have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| hdlc_mode | input | 1 | High: external pins used for another function, insertion disabled |
| payload_in | input | 1 | Payload bit for the current position |
| oh_data | input | 1 | External overhead bit |
| oh_insert | input | 1 | Insert qualifier for `oh_data` |
| oh_enable | output | 1 | One-cycle warning before an overhead slot |
| ser_out | output | 1 | Registered serial frame output |
| ins_reject | output | 1 | One-cycle pulse when a request hits a locked slot |

## Verification
A wrong frame counter moves the enable pulse, and the bench compares the pulse against its own position count on every cycle. A slipped count therefore appears within one cycle, and the overhead bits land among payload bits within the same frame. A stale or mistimed capture register shows up in the next overhead slot as a default where an inserted bit was expected, or the other way round. The locked-slot mask is exercised once per frame, so an error in it shows as a missing or extra `ins_reject` pulse, or a wrong bit at position 16, within 32 cycles.

// File: rtl/ovh_pkg.sv
package ovh_pkg;

  // position reached after stepping forward, modulo frame length
  function automatic int wrap_add(int pos, int step, int len);
    return (pos + step) % len;
  endfunction

  // an overhead slot sits on every stride-th position
  function automatic logic slot_is_oh(int pos, int stride);
    return (pos % stride) == 0;
  endfunction

  // ordinal of the overhead slot that owns a position
  function automatic int slot_index(int pos, int stride);
    return pos / stride;
  endfunction

endpackage

// File: rtl/ovh_slot_counter.sv
module ovh_slot_counter
  import ovh_pkg::*;
#(
  parameter int FRAME_LEN = 32,
  parameter int OH_STRIDE = 8,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] pos_o,
  output logic             oh_en_o
);

  // oh_en_o is registered one step ahead: it is high while pos_o sits
  // on the position just before an overhead slot
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o   <= '0;
      oh_en_o <= 1'b0;
    end else begin
      pos_o   <= CNT_W'(wrap_add(int'(pos_o), 1, FRAME_LEN));
      oh_en_o <= slot_is_oh(wrap_add(int'(pos_o), 2, FRAME_LEN), OH_STRIDE);
    end
  end

endmodule

// File: rtl/ovh_capture.sv
module ovh_capture (
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  input  logic hdlc_i,
  input  logic data_i,
  input  logic ins_i,
  output logic bit_q,
  output logic req_q
);

  // capture only on the edge that closes an enable cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      req_q <= 1'b0;
    end else if (take_i) begin
      bit_q <= data_i;
      req_q <= ins_i & ~hdlc_i;
    end
  end

endmodule

// File: rtl/ovh_slot_mux.sv
module ovh_slot_mux
  import ovh_pkg::*;
#(
  parameter int                        FRAME_LEN   = 32,
  parameter int                        OH_STRIDE   = 8,
  parameter int                        CNT_W       = 5,
  parameter int                        IDX_W       = 2,
  parameter logic [FRAME_LEN/OH_STRIDE-1:0] DEFAULT_PAT = '0,
  parameter logic [FRAME_LEN/OH_STRIDE-1:0] LOCK_MASK   = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] pos_i,
  input  logic             payload_i,
  input  logic             bit_i,
  input  logic             req_i,
  output logic             slot_oh_o,
  output logic             use_ext_o,
  output logic             rej_now_o,
  output logic             ser_o,
  output logic             rej_o
);

  logic [IDX_W-1:0] idx;
  logic             locked;
  logic             nxt_bit;

  always_comb begin
    slot_oh_o = slot_is_oh(int'(pos_i), OH_STRIDE);
    idx       = IDX_W'(slot_index(int'(pos_i), OH_STRIDE));
    locked    = LOCK_MASK[idx];
    use_ext_o = slot_oh_o & req_i & ~locked;
    rej_now_o = slot_oh_o & req_i & locked;
    if (!slot_oh_o)     nxt_bit = payload_i;
    else if (use_ext_o) nxt_bit = bit_i;
    else                nxt_bit = DEFAULT_PAT[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_o <= 1'b0;
      rej_o <= 1'b0;
    end else begin
      ser_o <= nxt_bit;
      rej_o <= rej_now_o;
    end
  end

endmodule

// File: rtl/ovh_insert.sv
module ovh_insert #(
  parameter int                             FRAME_LEN   = 32,
  parameter int                             OH_STRIDE   = 8,
  parameter logic [FRAME_LEN/OH_STRIDE-1:0] DEFAULT_PAT = 4'b1010,
  parameter logic [FRAME_LEN/OH_STRIDE-1:0] LOCK_MASK   = 4'b0100
) (
  input  logic clk,
  input  logic rst,
  input  logic hdlc_mode,
  input  logic payload_in,
  input  logic oh_data,
  input  logic oh_insert,
  output logic oh_enable,
  output logic ser_out,
  output logic ins_reject
);

  localparam int OH_COUNT = FRAME_LEN / OH_STRIDE;
  localparam int CNT_W    = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam int IDX_W    = (OH_COUNT > 1) ? $clog2(OH_COUNT) : 1;

  // named internal events, observed by the bound checker
  logic [CNT_W-1:0] pos;
  logic             cap_bit;
  logic             cap_req;
  logic             slot_oh;
  logic             use_ext;
  logic             rej_now;

  ovh_slot_counter #(
    .FRAME_LEN(FRAME_LEN),
    .OH_STRIDE(OH_STRIDE),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .pos_o  (pos),
    .oh_en_o(oh_enable)
  );

  ovh_capture u_cap (
    .clk   (clk),
    .rst   (rst),
    .take_i(oh_enable),
    .hdlc_i(hdlc_mode),
    .data_i(oh_data),
    .ins_i (oh_insert),
    .bit_q (cap_bit),
    .req_q (cap_req)
  );

  ovh_slot_mux #(
    .FRAME_LEN  (FRAME_LEN),
    .OH_STRIDE  (OH_STRIDE),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W),
    .DEFAULT_PAT(DEFAULT_PAT),
    .LOCK_MASK  (LOCK_MASK)
  ) u_mux (
    .clk      (clk),
    .rst      (rst),
    .pos_i    (pos),
    .payload_i(payload_in),
    .bit_i    (cap_bit),
    .req_i    (cap_req),
    .slot_oh_o(slot_oh),
    .use_ext_o(use_ext),
    .rej_now_o(rej_now),
    .ser_o    (ser_out),
    .rej_o    (ins_reject)
  );

endmodule

// File: rtl/ovh_insert_checker.sv
module ovh_insert_checker #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             hdlc_mode,
  input logic             payload_in,
  input logic             oh_enable,
  input logic             ser_out,
  input logic             ins_reject,
  input logic [CNT_W-1:0] pos,
  input logic             cap_bit,
  input logic             slot_oh,
  input logic             use_ext,
  input logic             rej_now
);

  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    oh_enable |=> !oh_enable); // R1

  AST_EN_LEADS_SLOT: assert property (@(posedge clk) disable iff (rst)
    oh_enable |=> slot_oh); // R1

  AST_ACCEPT_DRIVES_OUT: assert property (@(posedge clk) disable iff (rst)
    use_ext |=> (ser_out == $past(cap_bit))); // R4

  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (rst)
    rej_now |=> ins_reject); // R5

  AST_ACCEPT_XOR_REJECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({use_ext, rej_now})); // R5

  AST_HDLC_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (oh_enable && hdlc_mode) |=> (!use_ext && !rej_now)); // R6

  AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (rst)
    !slot_oh |=> (ser_out == $past(payload_in))); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pos == '0 && !oh_enable && !ser_out)); // R8

endmodule

bind ovh_insert ovh_insert_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hdlc_mode (hdlc_mode),
  .payload_in(payload_in),
  .oh_enable (oh_enable),
  .ser_out   (ser_out),
  .ins_reject(ins_reject),
  .pos       (pos),
  .cap_bit   (cap_bit),
  .slot_oh   (slot_oh),
  .use_ext   (use_ext),
  .rej_now   (rej_now)
);

// File: tb/test_ovh_insert.sv
`timescale 1ns/1ps
module test_ovh_insert;

  localparam int         FL   = 32;
  localparam int         ST   = 8;
  localparam logic [3:0] DEF  = 4'b1010;
  localparam logic [3:0] LOCK = 4'b0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hdlc_mode = 1'b0;
  logic payload_in = 1'b0;
  logic oh_data = 1'b0;
  logic oh_insert = 1'b0;
  logic oh_enable, ser_out, ins_reject;

  always #2 clk = ~clk;

  ovh_insert #(.FRAME_LEN(FL), .OH_STRIDE(ST), .DEFAULT_PAT(DEF), .LOCK_MASK(LOCK))
    i_ovh_insert (
      .clk(clk), .rst(rst), .hdlc_mode(hdlc_mode), .payload_in(payload_in),
      .oh_data(oh_data), .oh_insert(oh_insert), .oh_enable(oh_enable),
      .ser_out(ser_out), .ins_reject(ins_reject));

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  int    bpos;
  bit    first;
  bit    cur_req, cur_bit, pend_req, pend_bit, alt;
  bit    exp_ser, exp_rej;
  string exp_tag;
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit is_oh_b(int p);
    return (p % ST) == 0;
  endfunction

  task automatic check(bit ok, string tag, logic act, logic expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (pos %0d)", tag, act, expv, bpos);
    end
  endtask

  // policy: 0 no request, 1 request every slot, 2 qualifier low, 3 alternate
  task automatic step(int pol);
    int nxt;
    if (!first) begin
      check(ser_out === exp_ser, exp_tag, ser_out, exp_ser);
      check(ins_reject === exp_rej, "R5 ins_reject", ins_reject, exp_rej);
    end
    check(oh_enable === is_oh_b((bpos + 1) % FL), "R1 oh_enable", oh_enable,
          is_oh_b((bpos + 1) % FL));
    first   = 0;
    cur_req = pend_req;
    cur_bit = pend_bit;
    pend_req = 0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    payload_in = lfsr[0];
    if (is_oh_b((bpos + 1) % FL)) begin
      nxt = ((bpos + 1) % FL) / ST;
      oh_data = ~DEF[nxt];
      alt = ~alt;
      case (pol)
        1: oh_insert = 1'b1;
        3: oh_insert = alt;
        default: oh_insert = 1'b0;
      endcase
      pend_req = oh_insert && !hdlc_mode;
      pend_bit = oh_data;
    end else begin
      // R9: noise outside the capture window
      oh_data   = lfsr[3];
      oh_insert = lfsr[5];
    end
    if (!is_oh_b(bpos)) begin
      exp_ser = payload_in; exp_rej = 0; exp_tag = "R7 payload";
    end else if (cur_req && !LOCK[bpos / ST]) begin
      exp_ser = cur_bit; exp_rej = 0; exp_tag = "R4 inserted";
    end else begin
      exp_ser = DEF[bpos / ST];
      exp_rej = cur_req;
      exp_tag = cur_req ? "R5 locked default" : "R2/R3/R6/R9 default";
    end
    bpos = (bpos + 1) % FL;
    @(negedge clk);
  endtask

  task automatic run(int n, int pol);
    for (int i = 0; i < n; i++) step(pol);
  endtask

  task automatic t_reset();
    rst = 1'b1; oh_insert = 1'b1; oh_data = 1'b1;
    repeat (3) @(negedge clk);
    check(oh_enable === 1'b0, "R8 enable in reset", oh_enable, 1'b0);
    check(ser_out === 1'b0, "R8 ser_out in reset", ser_out, 1'b0);
    check(ins_reject === 1'b0, "R8 reject in reset", ins_reject, 1'b0);
    rst = 1'b0;
    bpos = 0; first = 1; pend_req = 0; alt = 0;
  endtask

  task automatic t_defaults();     // R1 R2 R7 R8
    hdlc_mode = 1'b0; run(2 * FL, 0);
  endtask

  task automatic t_insert();       // R4 R5 R9
    hdlc_mode = 1'b0; run(2 * FL, 1);
  endtask

  task automatic t_qual_low();     // R3
    hdlc_mode = 1'b0; run(FL, 2);
  endtask

  task automatic t_alternate();    // R3 R4 R5
    hdlc_mode = 1'b0; run(3 * FL, 3);
  endtask

  task automatic t_hdlc();         // R6
    hdlc_mode = 1'b1; run(2 * FL, 1);
    hdlc_mode = 1'b0; run(FL, 1);
  endtask

  task automatic t_mid_reset();    // R8: counter restarts from position 0
    run(13, 1);
    t_reset();
    run(FL + 2, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_defaults();
    t_insert();
    t_qual_low();
    t_alternate();
    t_hdlc();
    t_mid_reset();
    step(0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule